// File: doc/BRIEF.md
# Instruction-Controlled Barrel Shifter

This block shifts a data word by a count taken from a second register operand. Two bits of an instruction's mode field pick the operation. One bit picks the direction. For right shifts, a second bit picks between sign fill and zero fill. Only the low bits of the count operand that can index a bit of the word are used.

The shifter is a logarithmic network. Each stage shifts by a power of two and is enabled by one bit of the count. A parameter sets the latency: 0 gives a purely combinational path, and 1 puts a register on the result and its valid flag.

Top module: `insn_barrel_shift`

## Requirements
- R1: With mode bit 10 set, the result is the data operand shifted toward the MSB by the count, and the vacated low bits are filled with zeros.
- R2: With mode bit 10 clear and mode bit 9 set, the result is an arithmetic right shift, and the vacated high bits take copies of data bit 31.
- R3: With mode bits 10 and 9 both clear, the result is a logical right shift, and the vacated high bits are zeros.
- R4: Only count bits [4:0] set the shift distance. Count bits [31:5] have no effect on the result.
- R5: A count of zero in bits [4:0] returns the data operand unchanged in all three modes.
- R6: Mode bit 9 has no effect when mode bit 10 is set. Mode bits other than 10 and 9 have no effect at all.
- R7: The result valid flag equals the input strobe, delayed by LATENCY cycles (0 or 1). The result belongs to the operands presented that many cycles earlier.
- R8: After reset with LATENCY=1, the result valid flag is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when LATENCY=1) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid strobe |
| data_in | input | 32 | Word to be shifted |
| amount_in | input | 32 | Count operand; low 5 bits used |
| mode_in | input | 11 | Mode field; bit 10 = left, bit 9 = arithmetic |
| res_valid | output | 1 | Result valid |
| res_out | output | 32 | Shifted word |

## Verification
The bench builds the shifter with LATENCY=1. Each result is due on the first rising edge after its operands are applied, so every operation is driven just after an edge and checked at the next falling edge. At that point the registered result holds those operands and nothing else. The expected value is computed with the language's own shift operators. The bench sweeps all 32 counts in every mode over several data patterns, with junk in the unused count and mode bits. It also checks that a strobe that is low gives a low valid flag one cycle later.

// File: rtl/insn_barrel_shift.sv
module insn_barrel_shift #(
  parameter int W       = 32,
  parameter int MODE_W  = 11,
  parameter int LATENCY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      data_in,
  input  logic [W-1:0]      amount_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic              res_valid,
  output logic [W-1:0]      res_out
);
  localparam int SW = $clog2(W);

  logic          go_left, arith, fill;
  logic [SW-1:0] amt;
  logic [W-1:0]  stg [SW+1];
  logic [W-1:0]  shifted;

  assign go_left = mode_in[10];
  assign arith   = ~go_left & mode_in[9];
  assign fill    = arith & data_in[W-1];
  assign amt     = amount_in[SW-1:0];

  // Left shifts reuse the right-shift network by reversing the bits on the way in and out.
  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) rev[i] = v[W-1-i];
  endfunction

  assign stg[0] = go_left ? rev(data_in) : data_in;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
  end

  assign shifted = go_left ? rev(stg[SW]) : stg[SW];

  if (LATENCY == 0) begin : g_comb
    assign res_out   = shifted;
    assign res_valid = in_valid;
  end else begin : g_reg
    logic [W-1:0] r_q;
    logic         v_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
        v_q <= 1'b0;
      end else begin
        r_q <= shifted;
        v_q <= in_valid;
      end
    end
    assign res_out   = r_q;
    assign res_valid = v_q;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
    // R7
    invalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
    // R5
    zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amt == '0) |=> (res_out == $past(data_in)));
    // R1
    left_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_left && amt != '0) |=> (res_out[0] == 1'b0));
    // R3
    logical_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_in[10] && !mode_in[9] && amt != '0) |=> (res_out[W-1] == 1'b0));
    // R2
    arith_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_in[10] && mode_in[9]) |=> (res_out[W-1] == $past(data_in[W-1])));
  end
endmodule

// File: tb/insn_barrel_shift_tb.sv
`timescale 1ns/1ps
module insn_barrel_shift_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] data_in = '0, amount_in = '0;
  logic [10:0] mode_in = '0;
  logic        res_valid;
  logic [31:0] res_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  insn_barrel_shift #(.W(32), .MODE_W(11), .LATENCY(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
    .amount_in(amount_in), .mode_in(mode_in), .res_valid(res_valid), .res_out(res_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] d, input logic [31:0] a,
                     input logic [10:0] m);
    logic [31:0] e;
    logic [4:0]  n;
    n = a[4:0];
    if (m[10])     e = d << n;
    else if (m[9]) e = $unsigned($signed(d) >>> n);
    else           e = d >> n;
    @(posedge clk); #0.5;
    data_in = d; amount_in = a; mode_in = m; in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req, res_out, e);
    chk(req, {31'd0, res_valid}, 32'd1);
  endtask

  logic [31:0] pats [6] = '{32'h8000_0001, 32'hDEAD_BEEF, 32'h7FFF_FFFF,
                            32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678};

  initial begin
    fork
      begin #900000; fails++; $display("FAIL watchdog expired"); end
      begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 res_out", res_out, 32'd0);
        chk("R8 res_valid", {31'd0, res_valid}, 32'd0);
        @(posedge clk); #0.5; rst_n = 1'b1;
        foreach (pats[p]) begin
          for (int n = 0; n < 32; n++) begin
            run("R1 left", pats[p], n, 11'h400);
            run("R2 arith", pats[p], n, 11'h200);
            run("R3 logical", pats[p], n, 11'h000);
          end
        end
        for (int k = 0; k < 3; k++) begin
          logic [10:0] mm;
          mm = (k == 0) ? 11'h400 : (k == 1) ? 11'h200 : 11'h000;
          run("R5 zero count", 32'hA5C3_0F96, 32'd0, mm);
          run("R4 upper count bits", 32'h9ABC_DEF1, 32'hFFFF_FFE0 | 32'd5, mm);
          run("R4 upper-only count", 32'h9ABC_DEF1, 32'h8000_0020, mm);
        end
        run("R6 bit9 with left", 32'hF000_000F, 32'd4, 11'h600);
        run("R6 other mode bits", 32'hF000_000F, 32'd4, 11'h1FF);
        run("R6 other mode bits left", 32'hF000_000F, 32'd7, 11'h5FF);
        @(posedge clk); #0.5; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 valid low", {31'd0, res_valid}, 32'd0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule